// File: doc/BRIEF.md
# Demodulator Lock Status and Change Interrupt Unit

This unit watches the synchronisation state of a multicarrier broadcast demodulator. Four acquisition loops (frame, carrier frequency, FFT window start and sample clock) each report a lock level. The signalling decoder reports a strobe once per frame, a checksum-valid indication and the decoded signalling word. The unit keeps a five-bit lock status register. A fifth lock bit follows signalling frame quality: it is set by a clean frame and cleared by a corrupted one.

The unit raises two sticky events. The sync-change event is raised when any of the five lock bits changes value. The signalling-change event is raised when a checksum-valid signalling word differs from the stored copy in any field other than the frame counter. Each event has its own output. The events are combined, each under its own enable bit, into one interrupt line. A processor reaches the unit through a small register port: it reads the status, reads the events (the read also clears them), sets the enables and reads back the stored word.

Top module: `demod_sync_irq`

## Requirements
- R1: While rst_ni is low, and after it rises, every readable register (status, events, enables, stored word) is zero. irq_o, sync_chg_o and sig_chg_o are 0.
- R2: Status bits 3..0 take the value of loop_lock_i[3..0] at each clock edge. They are read at address 0 in bits 3..0, in the order frame, frequency, FFT start, sample clock.
- R3: Status bit 4 (signalling lock) takes the value of sig_ok_i at each edge where sig_frame_i is 1, and holds its value otherwise.
- R4: The sync-change event (event bit 0) is set at every edge where at least one of the five status bits changes value.
- R5: The signalling-change event (event bit 1) is set only at an edge where sig_frame_i and sig_ok_i are both 1 and sig_word_i differs from the stored word outside the frame-counter field (bits FN_LSB+FN_W-1..FN_LSB, default bits 1..0). A difference only inside that field, or a word with sig_ok_i at 0, leaves the event unchanged.
- R6: The stored word is replaced by sig_word_i at every edge where sig_frame_i and sig_ok_i are both 1. The comparison uses the value stored before that update. The stored word is read at address 3.
- R7: The events are cleared only by a read (reg_rd_i) at address 1. Reads at other addresses, writes and the passing of time leave them unchanged. Address 1 returns the sync event in bit 0 and the signalling event in bit 1.
- R8: If an event is set in the same cycle as the clearing read, the event stays set.
- R9: irq_o is 1 when (event bit 0 AND enable bit 0) OR (event bit 1 AND enable bit 1). The enables are written with reg_wr_i at address 2, taken from reg_wdata_i[1:0], and read back there.
- R10: sync_chg_o and sig_chg_o always equal event bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loop_lock_i | input | 4 | Lock levels: frame, frequency, FFT start, sample clock |
| sig_frame_i | input | 1 | One-cycle strobe per received signalling frame |
| sig_ok_i | input | 1 | Signalling checksum valid, qualified by sig_frame_i |
| sig_word_i | input | SIG_W | Decoded signalling word |
| reg_addr_i | input | 2 | Register address |
| reg_rd_i | input | 1 | Read access strobe |
| reg_wr_i | input | 1 | Write access strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Enabled-event interrupt |
| sync_chg_o | output | 1 | Sync-change event level |
| sig_chg_o | output | 1 | Signalling-change event level |

## Verification
The hardest case to reach from the ports is a clearing read that lands in the same cycle as a fresh event. The fresh event can be a loop lock toggle or a valid word that differs outside the frame counter. The bench places such reads on purpose. It also sets up frames whose words differ only in the counter field, and corrupted frames that carry a new word. During a long random phase, the reads, lock toggles and frame strobes overlap freely. A behavioural model follows every cycle, and every output and the read data are compared against it on each clock.

// File: rtl/demod_sync_pkg.sv
package demod_sync_pkg;
  localparam int unsigned NUM_LOOP = 4;
  localparam int unsigned NUM_LOCK = NUM_LOOP + 1;
  localparam int unsigned NUM_EVT  = 2;
  localparam int unsigned EVT_SYNC = 0;
  localparam int unsigned EVT_SIG  = 1;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_EVENT  = 2'd1,
    REG_ENABLE = 2'd2,
    REG_WORD   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/loop_lock_track.sv
module loop_lock_track #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lock_i,
  output logic [N-1:0] status_o,
  output logic         toggle_o
);
  logic [N-1:0] status_q;
  logic [N-1:0] toggle;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q[i] <= 1'b0;
      else         status_q[i] <= lock_i[i];
    end
    assign toggle[i] = lock_i[i] ^ status_q[i];
  end

  assign status_o = status_q;
  assign toggle_o = |toggle;

  a_r2_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_q == $past(lock_i));
endmodule

// File: rtl/sig_word_track.sv
module sig_word_track #(
  parameter int unsigned SIG_W  = 24,
  parameter int unsigned FN_LSB = 0,
  parameter int unsigned FN_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             ok_i,
  input  logic [SIG_W-1:0] word_i,
  output logic             lock_o,
  output logic             lock_toggle_o,
  output logic [SIG_W-1:0] stored_o,
  output logic             differ_o
);
  localparam logic [SIG_W-1:0] FnMask =
    {{(SIG_W-FN_W){1'b0}}, {FN_W{1'b1}}} << FN_LSB;

  logic             lock_q;
  logic [SIG_W-1:0] stored_q;
  logic             accept;

  assign accept = frame_i & ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q   <= 1'b0;
      stored_q <= '0;
    end else begin
      if (frame_i) lock_q   <= ok_i;
      if (accept)  stored_q <= word_i;
    end
  end

  // content compare, frame counter ignored, against pre-update copy
  assign differ_o      = accept && (((word_i ^ stored_q) & ~FnMask) != '0);
  assign lock_toggle_o = frame_i && (ok_i != lock_q);
  assign lock_o        = lock_q;
  assign stored_o      = stored_q;

  a_r3_lock_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> lock_q == $past(ok_i));
  a_r3_lock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(lock_q));
  a_r6_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && ok_i) |=> stored_q == $past(word_i));
  a_r6_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_i && ok_i) |=> $stable(stored_q));
endmodule

// File: rtl/event_regs.sv
module event_regs #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clear_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_wdata_i,
  output logic [N-1:0] event_o,
  output logic [N-1:0] enable_o,
  output logic         irq_o
);
  logic [N-1:0] event_q;
  logic [N-1:0] enable_q;

  for (genvar i = 0; i < N; i++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         event_q[i] <= 1'b0;
      else if (set_i[i])   event_q[i] <= 1'b1;  // set beats clear
      else if (clear_i)    event_q[i] <= 1'b0;
    end

    a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (event_q[i] && !clear_i) |=> event_q[i]);
    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> event_q[i]);
    a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!event_q[i] && !set_i[i]) |=> !event_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      enable_q <= '0;
    else if (en_wr_i) enable_q <= en_wdata_i;
  end

  assign event_o  = event_q;
  assign enable_o = enable_q;
  assign irq_o    = |(event_q & enable_q);
endmodule

// File: rtl/demod_sync_irq.sv
module demod_sync_irq
  import demod_sync_pkg::*;
#(
  parameter int unsigned SIG_W  = 24,
  parameter int unsigned FN_LSB = 0,
  parameter int unsigned FN_W   = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_LOOP-1:0] loop_lock_i,
  input  logic              sig_frame_i,
  input  logic              sig_ok_i,
  input  logic [SIG_W-1:0]  sig_word_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              sync_chg_o,
  output logic              sig_chg_o
);
  logic [NUM_LOOP-1:0] loop_status;
  logic                loop_toggle;
  logic                sig_lock;
  logic                sig_toggle;
  logic [SIG_W-1:0]    stored_word;
  logic                sig_differ;
  logic [NUM_EVT-1:0]  evt_set;
  logic [NUM_EVT-1:0]  evt;
  logic [NUM_EVT-1:0]  evt_en;
  logic                rd_clear;
  logic                en_wr;
  logic [NUM_LOCK-1:0] status;

  loop_lock_track #(.N(NUM_LOOP)) i_loops (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_i   (loop_lock_i),
    .status_o (loop_status),
    .toggle_o (loop_toggle)
  );

  sig_word_track #(.SIG_W(SIG_W), .FN_LSB(FN_LSB), .FN_W(FN_W)) i_sig (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_i       (sig_frame_i),
    .ok_i          (sig_ok_i),
    .word_i        (sig_word_i),
    .lock_o        (sig_lock),
    .lock_toggle_o (sig_toggle),
    .stored_o      (stored_word),
    .differ_o      (sig_differ)
  );

  assign status            = {sig_lock, loop_status};
  assign evt_set[EVT_SYNC] = loop_toggle | sig_toggle;
  assign evt_set[EVT_SIG]  = sig_differ;
  assign rd_clear          = reg_rd_i && (reg_addr_i == REG_EVENT);
  assign en_wr             = reg_wr_i && (reg_addr_i == REG_ENABLE);

  event_regs #(.N(NUM_EVT)) i_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (evt_set),
    .clear_i    (rd_clear),
    .en_wr_i    (en_wr),
    .en_wdata_i (reg_wdata_i[NUM_EVT-1:0]),
    .event_o    (evt),
    .enable_o   (evt_en),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_STATUS: reg_rdata_o[NUM_LOCK-1:0] = status;
      REG_EVENT:  reg_rdata_o[NUM_EVT-1:0]  = evt;
      REG_ENABLE: reg_rdata_o[NUM_EVT-1:0]  = evt_en;
      default:    reg_rdata_o[SIG_W-1:0]    = stored_word;
    endcase
  end

  assign sync_chg_o = evt[EVT_SYNC];
  assign sig_chg_o  = evt[EVT_SIG];

  a_r4_loop_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_lock_i != loop_status) |=> sync_chg_o);
  a_r5_bad_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sig_chg_o && !(sig_frame_i && sig_ok_i)) |=> !sig_chg_o);
  a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clear && !sig_differ) |=> !sig_chg_o);
endmodule

// File: tb/test_demod_sync_irq.sv
module test_demod_sync_irq;
  localparam int SIG_W = 24;
  localparam logic [SIG_W-1:0] FNM = 24'h000003;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [3:0]        lock = '0;
  logic              frm = 1'b0, ok = 1'b0;
  logic [SIG_W-1:0]  word = '0;
  logic [1:0]        addr = '0;
  logic              rd = 1'b0, wr = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              irq, syncc, sigc;

  int total = 0, bad = 0, cycles = 0;

  // reference state
  logic [4:0]       m_st;
  logic [SIG_W-1:0] m_word;
  logic             m_sync, m_sig;
  logic [1:0]       m_en;

  always #5 clk = ~clk;

  demod_sync_irq i_demod_sync_irq (
    .clk_i(clk), .rst_ni(rst_ni), .loop_lock_i(lock), .sig_frame_i(frm),
    .sig_ok_i(ok), .sig_word_i(word), .reg_addr_i(addr), .reg_rd_i(rd),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .sync_chg_o(syncc), .sig_chg_o(sigc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    m_st = '0; m_word = '0; m_sync = 0; m_sig = 0; m_en = '0;
  endtask

  function automatic logic [31:0] m_rdata();
    case (addr)
      2'd0:    return {27'd0, m_st};
      2'd1:    return {30'd0, m_sig, m_sync};
      2'd2:    return {30'd0, m_en};
      default: return {8'd0, m_word};
    endcase
  endfunction

  task automatic compare_all();
    chk((addr == 2'd0) ? "R2,R3 status" : (addr == 2'd3) ? "R6 word" :
        (addr == 2'd1) ? "R7 events" : "R9 enable", rdata, m_rdata());
    chk("R10 sync_chg_o", {31'd0, syncc}, {31'd0, m_sync});
    chk("R10 sig_chg_o", {31'd0, sigc}, {31'd0, m_sig});
    chk("R9 irq_o", {31'd0, irq}, {31'd0, (m_sync & m_en[0]) | (m_sig & m_en[1])});
  endtask

  // inputs are set after a negedge; compare, then advance one clock
  task automatic tick();
    logic tog, dif, clr;
    #1 compare_all();
    @(posedge clk);
    tog = (lock != m_st[3:0]) || (frm && (ok != m_st[4]));
    dif = frm && ok && ((((word ^ m_word) & ~FNM)) != '0);
    clr = rd && (addr == 2'd1);
    m_sync = (m_sync && !clr) || tog;
    m_sig  = (m_sig && !clr) || dif;
    m_st[3:0] = lock;
    if (frm) m_st[4] = ok;
    if (frm && ok) m_word = word;
    if (wr && addr == 2'd2) m_en = wdata[1:0];
    @(negedge clk);
  endtask

  task automatic idle();
    frm = 0; ok = 0; rd = 0; wr = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0; idle(); lock = '0; m_reset();
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      addr = a[1:0];
      #1 chk("R1 reset reg", rdata, 32'd0);
    end
    chk("R1 reset irq", {29'd0, irq, syncc, sigc}, 32'd0);
    @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic frame(input logic okv, input logic [SIG_W-1:0] w);
    frm = 1; ok = okv; word = w; tick(); frm = 0; ok = 0;
  endtask

  task automatic rd_evt();
    addr = 2'd1; rd = 1; tick(); rd = 0;
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) cycles++;

  initial begin
    do_reset();
    // R1 first cycle after reset still zero
    addr = 2'd1; tick();
    // R9 enable both
    addr = 2'd2; wr = 1; wdata = 32'h3; tick(); wr = 0; tick();
    // R2 R4 loops lock one by one
    for (int i = 0; i < 4; i++) begin
      lock[i] = 1; addr = 2'd0; tick(); tick();
      chk("R4 sync set after lock rise", {31'd0, syncc}, 32'd1);
      rd_evt();
      chk("R7 read clears sync", {31'd0, syncc}, 32'd0);
    end
    // R5 first valid word differing only in frame counter
    frame(1, 24'h000002);
    chk("R5 counter-only diff no event", {31'd0, sigc}, 32'd0);
    chk("R3 sig lock toggle sync", {31'd0, syncc}, 32'd1);
    rd_evt();
    frame(1, 24'h123404);
    chk("R5 content diff sets event", {31'd0, sigc}, 32'd1);
    addr = 2'd3; tick();
    chk("R6 stored word", rdata, 32'h00123404);
    // R7 other accesses do not clear
    addr = 2'd0; rd = 1; tick(); addr = 2'd2; wr = 1; wdata = 32'h3; tick();
    rd = 0; wr = 0; addr = 2'd1; tick();
    chk("R7 no clear by other access", {31'd0, sigc}, 32'd1);
    rd_evt();
    // R5 corrupted frame with new content: no event, lock drops, no store
    frame(0, 24'hABCDEF);
    chk("R5 bad frame no event", {31'd0, sigc}, 32'd0);
    chk("R3 lock drop sync", {31'd0, syncc}, 32'd1);
    addr = 2'd3; tick();
    chk("R6 bad frame not stored", rdata, 32'h00123404);
    rd_evt();
    frame(1, 24'h123407);
    chk("R5 counter-only vs stored", {31'd0, sigc}, 32'd0);
    // R8 set and clear in same cycle
    addr = 2'd1; rd = 1; lock[2] = 0; frm = 1; ok = 1; word = 24'h555500; tick();
    rd = 0; frm = 0; ok = 0;
    chk("R8 sync set wins", {31'd0, syncc}, 32'd1);
    chk("R8 sig set wins", {31'd0, sigc}, 32'd1);
    // R9 masking
    addr = 2'd2; wr = 1; wdata = 32'h0; tick(); wr = 0;
    chk("R9 masked irq low", {31'd0, irq}, 32'd0);
    wr = 1; wdata = 32'h2; tick(); wr = 0;
    chk("R9 sig enable irq", {31'd0, irq}, 32'd1);
    rd_evt();
    // random overlap
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 0) lock[r[5:4]] = ~lock[r[5:4]];
      frm = (r[9:7] == 0); ok = r[10];
      word = m_word ^ (r[11] ? {r[31:16], 8'h00} : {22'd0, r[13:12]});
      addr = r[15:14]; rd = r[16] & r[17]; wr = (r[19:18] == 0); wdata = {30'd0, r[21:20]};
      tick();
    end
    idle();
    // R1 reset mid-run, then first word
    do_reset();
    tick();
    frame(1, 24'h000100);
    chk("R5 first word after reset differs", {31'd0, sigc}, 32'd1);
    tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule